// File: doc/BRIEF.md
# Descriptor Job Ring Controller

This block sits between host software and a processing engine and runs two circular rings of descriptor slots held in system memory. Software fills slots of the inbound ring, then writes a count to announce them. The controller hands the announced slots to the engine one at a time, in the order they were announced, as a slot pointer. When the engine reports a finished job, it returns that job's descriptor address. The controller then emits a write of that address into the next outbound ring slot. Software reads the number of waiting results, consumes them, and writes back how many it freed.

Both sides use counted credits. A read-only register shows how many inbound slots software may still fill, and another shows how many outbound results are waiting. A count written that is larger than the matching credit is refused, and it raises an error status bit. Completions raise a done status bit, either on every completion or, with coalescing, only once a set number of completions has built up. The interrupt output is high while any status bit is set. Status bits clear when a 1 is written to them.

Register word offsets (on `reg_addr`):
- 0: control. Bit 0 enables job issue.
- 1 and 2: inbound base, high and low words.
- 3 and 4: outbound base, high and low words.
- 5 and 6: inbound and outbound ring size, as a log2 value.
- 7: inbound free count, read-only.
- 8: add-jobs, write-only.
- 9: outbound waiting count, read-only.
- 10: results-freed, write-only.
- 11: status. Bit 0 is done and bit 1 is error; both are write-1-to-clear.
- 12: coalescing threshold.

Top module: `job_ring_ctrl`

## Requirements
- R1: After reset, the inbound free count (offset 7) reads the maximum ring depth (16 by default). The outbound waiting count (offset 9) reads 0, and `irq` and `job_valid` are low.
- R2: An accepted add-jobs write of N (offset 8) lowers the inbound free count by N. The free count always equals the ring capacity minus the slots announced but not yet issued.
- R3: No job is issued while control bit 0 is clear. Once it is set, slots are issued in ring order. The pointer for slot i is the inbound base plus i times 16 bytes.
- R4: A size write (offset 5 or 6) stores min(value, log2 of the maximum depth), so 9 reads back as 4. The write takes effect only while issue is disabled and that ring is empty. Ring indexes wrap at the programmed capacity.
- R5: While a job is issued, `done_valid` causes a same-cycle `ob_we`. The outbound write goes to the outbound base plus the outbound index times 16, and carries the completed address. The waiting count rises by one.
- R6: An accepted results-freed write of N (offset 10) lowers the outbound waiting count by N.
- R7: A job is issued only while the waiting results plus the jobs in flight are fewer than the outbound capacity. Otherwise `job_valid` stays low.
- R8: An add-jobs count above the free count, a results-freed count above the waiting count, or a completion with no job in flight sets status bit 1. In each case the counters and the outbound ring are left unchanged.
- R9: With a threshold of 0, each completion sets status bit 0 and drives `irq` high. Writing 1 to bit 0 clears it.
- R10: With a threshold T greater than 0, status bit 0 sets only on the T-th completion since the last clear or the last threshold hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| job_valid | output | 1 | A slot is ready for the engine |
| job_ready | input | 1 | Engine takes the offered slot |
| job_ptr_hi | output | 32 | Offered slot pointer, high word |
| job_ptr_lo | output | 32 | Offered slot pointer, low word |
| done_valid | input | 1 | Engine finished the oldest issued job |
| done_hi | input | 32 | Completed descriptor address, high word |
| done_lo | input | 32 | Completed descriptor address, low word |
| ob_we | output | 1 | Outbound slot write strobe |
| ob_ptr_hi | output | 32 | Outbound slot pointer, high word |
| ob_ptr_lo | output | 32 | Outbound slot pointer, low word |
| ob_data_hi | output | 32 | Outbound entry, address high word |
| ob_data_lo | output | 32 | Outbound entry, address low word |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
Some properties are checked on every cycle:
- Inbound occupancy never exceeds the ring capacity.
- Waiting results plus jobs in flight never exceed the outbound capacity.
- A refused add or free count is always followed by the error bit.
- A completion with coalescing off always raises `irq` on the next cycle.

The rest can only be shown by the bench's scenarios:
- The exact slot pointers.
- Index wrap at a programmed size.
- The size clamp.
- The point at which coalescing fires.
- That refused counts leave the readable counters unchanged.

// File: rtl/job_ring_ctrl.sv
module job_ring_ctrl #(
  parameter int MAX_DEPTH   = 16,
  parameter int ENTRY_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        job_valid,
  input  logic        job_ready,
  output logic [31:0] job_ptr_hi,
  output logic [31:0] job_ptr_lo,
  input  logic        done_valid,
  input  logic [31:0] done_hi,
  input  logic [31:0] done_lo,
  output logic        ob_we,
  output logic [31:0] ob_ptr_hi,
  output logic [31:0] ob_ptr_lo,
  output logic [31:0] ob_data_hi,
  output logic [31:0] ob_data_lo,
  output logic        irq
);
  localparam int LG = $clog2(MAX_DEPTH);
  localparam int CW = LG + 1;
  localparam int SW = $clog2(LG + 1);
  localparam logic [SW-1:0] SZ_MAX = SW'(LG);

  logic          enable;
  logic [31:0]   in_base_hi, in_base_lo, out_base_hi, out_base_lo;
  logic [SW-1:0] in_sz, out_sz;
  logic [CW-1:0] in_queued, out_full, inflight, coal_thr, coal_cnt;
  logic [LG-1:0] in_idx, out_idx;
  logic [1:0]    stat;

  logic [CW-1:0] in_cap, out_cap, in_avail, add_n, rm_n;
  logic [LG-1:0] in_mask, out_mask;
  logic          wr_add, wr_rm, add_big, rm_big, add_ok, rm_ok;
  logic          handoff, done_ok, done_bad, thr_hit, clr_done;
  logic [SW-1:0] sz_w;
  logic [63:0]   job_ptr, ob_ptr;

  assign in_cap   = CW'(1) << in_sz;
  assign out_cap  = CW'(1) << out_sz;
  assign in_mask  = LG'(in_cap - CW'(1));
  assign out_mask = LG'(out_cap - CW'(1));
  assign in_avail = in_cap - in_queued;

  assign add_n   = reg_wdata[CW-1:0];
  assign rm_n    = reg_wdata[CW-1:0];
  assign wr_add  = reg_wr && reg_addr == 4'd8;
  assign wr_rm   = reg_wr && reg_addr == 4'd10;
  assign add_big = (|reg_wdata[31:CW]) || add_n > in_avail;
  assign rm_big  = (|reg_wdata[31:CW]) || rm_n > out_full;
  assign add_ok  = wr_add && !add_big;
  assign rm_ok   = wr_rm && !rm_big;
  assign sz_w    = (reg_wdata > 32'(LG)) ? SZ_MAX : reg_wdata[SW-1:0];

  assign job_valid = enable && in_queued != '0 &&
                     ({1'b0, out_full} + {1'b0, inflight} < {1'b0, out_cap});
  assign handoff   = job_valid && job_ready;
  assign done_ok   = done_valid && inflight != '0;
  assign done_bad  = done_valid && inflight == '0;
  assign thr_hit   = done_ok && (coal_thr == '0 ||
                     {1'b0, coal_cnt} + (CW+1)'(1) >= {1'b0, coal_thr});
  assign clr_done  = reg_wr && reg_addr == 4'd11 && reg_wdata[0];

  assign job_ptr    = {in_base_hi, in_base_lo} + 64'(in_idx) * 64'(ENTRY_BYTES);
  assign ob_ptr     = {out_base_hi, out_base_lo} + 64'(out_idx) * 64'(ENTRY_BYTES);
  assign job_ptr_hi = job_ptr[63:32];
  assign job_ptr_lo = job_ptr[31:0];
  assign ob_we      = done_ok;
  assign ob_ptr_hi  = ob_ptr[63:32];
  assign ob_ptr_lo  = ob_ptr[31:0];
  assign ob_data_hi = done_hi;
  assign ob_data_lo = done_lo;
  assign irq        = |stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable      <= 1'b0;
      in_base_hi  <= '0;
      in_base_lo  <= '0;
      out_base_hi <= '0;
      out_base_lo <= '0;
      in_sz       <= SZ_MAX;
      out_sz      <= SZ_MAX;
      coal_thr    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        4'd0:  enable      <= reg_wdata[0];
        4'd1:  in_base_hi  <= reg_wdata;
        4'd2:  in_base_lo  <= reg_wdata;
        4'd3:  out_base_hi <= reg_wdata;
        4'd4:  out_base_lo <= reg_wdata;
        4'd5:  if (!enable && in_queued == '0) in_sz <= sz_w;
        4'd6:  if (!enable && out_full == '0 && inflight == '0) out_sz <= sz_w;
        4'd12: coal_thr    <= reg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_queued <= '0;
      out_full  <= '0;
      inflight  <= '0;
      in_idx    <= '0;
      out_idx   <= '0;
    end else begin
      in_queued <= in_queued + (add_ok ? add_n : '0) - CW'(handoff);
      inflight  <= inflight + CW'(handoff) - CW'(done_ok);
      out_full  <= out_full + CW'(done_ok) - (rm_ok ? rm_n : '0);
      if (handoff) in_idx  <= (in_idx + LG'(1)) & in_mask;
      if (done_ok) out_idx <= (out_idx + LG'(1)) & out_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat     <= '0;
      coal_cnt <= '0;
    end else begin
      stat[0] <= thr_hit || (stat[0] && !clr_done);
      stat[1] <= (wr_add && add_big) || (wr_rm && rm_big) || done_bad ||
                 (stat[1] && !(reg_wr && reg_addr == 4'd11 && reg_wdata[1]));
      if (thr_hit)      coal_cnt <= '0;
      else if (done_ok) coal_cnt <= clr_done ? CW'(1) : coal_cnt + CW'(1);
      else if (clr_done) coal_cnt <= '0;
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = {31'd0, enable};
      4'd1:    reg_rdata = in_base_hi;
      4'd2:    reg_rdata = in_base_lo;
      4'd3:    reg_rdata = out_base_hi;
      4'd4:    reg_rdata = out_base_lo;
      4'd5:    reg_rdata = 32'(in_sz);
      4'd6:    reg_rdata = 32'(out_sz);
      4'd7:    reg_rdata = 32'(in_avail);
      4'd9:    reg_rdata = 32'(out_full);
      4'd11:   reg_rdata = {30'd0, stat};
      4'd12:   reg_rdata = 32'(coal_thr);
      default: reg_rdata = '0;
    endcase
  end

  p_in_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_queued <= in_cap);
  p_out_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, out_full} + {1'b0, inflight} <= {1'b0, out_cap});
  p_bad_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_add && add_big |=> stat[1]);
  p_bad_rm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rm && rm_big |=> stat[1]);
  p_done_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok && coal_thr == '0 |=> irq);
endmodule

// File: tb/sim_job_ring_ctrl.sv
module sim_job_ring_ctrl;
  localparam int CLK_P = 10;
  localparam logic [10:0] VEC [0:4] = '{
    {5'd1, 5'd3, 1'b0}, {5'd2, 5'd1, 1'b0}, {5'd3, 5'd1, 1'b1},
    {5'd1, 5'd0, 1'b0}, {5'd1, 5'd0, 1'b1}};

  logic clk = 0, rst_n = 0, reg_wr = 0, job_ready = 0, done_valid = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, done_hi = 0, done_lo = 0;
  logic [31:0] reg_rdata, job_ptr_hi, job_ptr_lo, ob_ptr_hi, ob_ptr_lo, ob_data_hi, ob_data_lo;
  logic job_valid, ob_we, irq;
  int checks = 0, errors = 0, in_idx_m = 0, out_idx_m = 0, finished = 0;
  logic [31:0] rv;

  always #(CLK_P/2) clk = ~clk;

  job_ring_ctrl u0 (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .job_valid, .job_ready, .job_ptr_hi, .job_ptr_lo, .done_valid, .done_hi, .done_lo,
    .ob_we, .ob_ptr_hi, .ob_ptr_lo, .ob_data_hi, .ob_data_lo, .irq);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic handoff(input int in_cap);
    chk("R3 job_valid", 64'(job_valid), 64'd1);
    chk("R3 job_ptr", {job_ptr_hi, job_ptr_lo}, 64'h1_0000_1000 + 64'(in_idx_m * 16));
    job_ready = 1;
    @(negedge clk); job_ready = 0;
    in_idx_m = (in_idx_m + 1) % in_cap;
  endtask

  task automatic complete(input logic [31:0] lo);
    done_valid = 1; done_hi = 32'hA; done_lo = lo; #1;
    chk("R5 ob_we", 64'(ob_we), 64'd1);
    chk("R5 ob_ptr", {ob_ptr_hi, ob_ptr_lo}, 64'h2_0000_8000 + 64'(out_idx_m * 16));
    chk("R5 ob_data", {ob_data_hi, ob_data_lo}, {32'hA, lo});
    @(negedge clk); done_valid = 0;
    out_idx_m = (out_idx_m + 1) % 2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(7, rv); chk("R1 avail", 64'(rv), 64'd16);
    rd(9, rv); chk("R1 full", 64'(rv), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 job_valid", 64'(job_valid), 64'd0);

    wr(5, 9); rd(5, rv); chk("R4 clamp", 64'(rv), 64'd4);
    wr(5, 2); rd(7, rv); chk("R4 in cap", 64'(rv), 64'd4);
    wr(6, 1); wr(1, 1); wr(2, 32'h1000); wr(3, 2); wr(4, 32'h8000);

    for (int i = 0; i < 5; i++) begin
      wr(8, 32'(VEC[i][10:6]));
      rd(7, rv); chk("R2 avail", 64'(rv), 64'(VEC[i][5:1]));
      rd(11, rv); chk("R8 add err", 64'(rv[1]), 64'(VEC[i][0]));
      if (VEC[i][0]) wr(11, 2);
    end

    chk("R3 disabled", 64'(job_valid), 64'd0);
    wr(0, 1);
    handoff(4);
    rd(7, rv); chk("R2 avail after issue", 64'(rv), 64'd1);
    complete(32'h1000);
    rd(9, rv); chk("R5 full", 64'(rv), 64'd1);
    chk("R9 irq", 64'(irq), 64'd1);
    rd(11, rv); chk("R9 done bit", 64'(rv), 64'd1);
    wr(11, 1); chk("R9 clear", 64'(irq), 64'd0);

    handoff(4);
    chk("R7 stall", 64'(job_valid), 64'd0);
    complete(32'h1010);
    wr(10, 3);
    rd(11, rv); chk("R8 rm err", 64'(rv[1]), 64'd1);
    rd(9, rv); chk("R8 full kept", 64'(rv), 64'd2);
    wr(11, 3);
    wr(10, 2);
    rd(9, rv); chk("R6 full", 64'(rv), 64'd0);
    chk("R7 resume", 64'(job_valid), 64'd1);

    handoff(4);
    complete(32'h1020);
    wr(10, 1);

    wr(12, 2); wr(11, 3);
    handoff(4);
    complete(32'h1030);
    chk("R10 no irq", 64'(irq), 64'd0);
    wr(8, 1);
    handoff(4);
    complete(32'h1000);
    chk("R10 irq", 64'(irq), 64'd1);

    wr(11, 3);
    done_valid = 1; #1;
    chk("R8 stray done no write", 64'(ob_we), 64'd0);
    @(negedge clk); done_valid = 0;
    rd(11, rv); chk("R8 stray done err", 64'(rv), 64'd2);
    rd(9, rv); chk("R8 stray done full", 64'(rv), 64'd2);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (finished == 0) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule